// File: doc/BRIEF.md
# Multi-Agent Read-to-Acquire Lock Register

This block is a single hardware lock that several independent bus agents share, for example a host driver, a firmware processor and one or more internal engines. Each agent reaches the lock through its own simple register port with an address, a read strobe, a write strobe, write data and read data. No agent needs a separate request/grant handshake. A read of the lock address is itself the atomic try-lock. It returns one and takes ownership when the lock is free, and it returns zero without side effects when the lock is taken. An agent that gets zero is expected to poll again later.

The lock is freed when its owner writes the value one to the lock address. When several agents read a free lock in the same cycle, a fixed-priority arbiter picks one of them, the lowest-numbered agent. Only the winner sees one. A status output shows whether the lock is held, which agent holds it, and a sticky flag that records any illegal release attempt.

Top module: `hw_try_lock_sem`

## Requirements
- R1: A read of the lock address (default 0xFD0) while the lock is free returns 1 on that agent's read data, marks the lock held, and records that agent's index as owner.
- R2: A read of the lock address while the lock is held returns 0 and leaves the held bit and the owner unchanged.
- R3: A write of value 1 to the lock address by the current owner frees the lock, and the status owner field returns to 0.
- R4: When several agents read the free lock in the same cycle, only the lowest-numbered reader gets 1 and becomes owner. Every other reader gets 0.
- R5: A read by the current owner returns 0 and keeps the lock held by the same owner. The lock is not recursive.
- R6: A write to the lock address by an agent that is not the owner, or a write of any value other than 1, changes neither held bit nor owner and sets the sticky error flag. Only reset clears that flag.
- R7: Read data appears exactly one clock after the read strobe and is 0 in every cycle that follows no winning read. A read in the same cycle as a release still sees the lock held. A read in the following cycle can acquire it.
- R8: A synchronous active-high reset frees the lock, sets the owner field to 0, clears the error flag and drives all read data to 0.
- R9: Reads and writes to any address other than the lock address return 0, leave the lock state unchanged and never set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | NUM_AGENTS*ADDR_W | Word address per agent, agent i in slice i |
| bus_rd | input | NUM_AGENTS | Read strobe per agent |
| bus_wr | input | NUM_AGENTS | Write strobe per agent |
| bus_wdata | input | NUM_AGENTS*DATA_W | Write data per agent |
| bus_rdata | output | NUM_AGENTS*DATA_W | Registered read data per agent |
| stat_locked | output | 1 | Lock is held |
| stat_owner | output | IDX_W | Index of the owning agent, 0 when free |
| stat_err | output | 1 | Sticky flag for illegal release writes |

## Verification
The bench aims at the races. Two or more readers on a free lock must give one winner. A design that grants by another priority, or that grants everyone, would return one to several agents. A read in the same cycle as the owner's release must still lose. A design that forwards the release would hand the lock over one cycle early. An owner that reads its own lock must get zero. A recursive design would answer one. Release writes from a non-owner, or with a value other than one, must be ignored and flagged. A loose design would free the lock for the wrong agent. Accesses to a neighbouring address must stay inert.

// File: rtl/hw_sem_pkg.sv
package hw_sem_pkg;

    // Decoded intent of one agent's port in one cycle
    typedef struct packed {
        logic try_lock;   // read of the lock address
        logic wr_lock;    // write of the lock address
        logic wr_is_one;  // that write carries the release value
    } sem_req_t;

    typedef struct packed {
        logic held;
        logic err;
    } sem_flags_t;

    localparam int unsigned RELEASE_VALUE = 1;

    function automatic logic value_is_release(input logic [63:0] v);
        return v == 64'(RELEASE_VALUE);
    endfunction

endpackage

// File: rtl/hw_sem_decode.sv
module hw_sem_decode
    import hw_sem_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hFD0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output sem_req_t          req
);
    logic hit;

    always_comb begin
        hit           = (addr == LOCK_ADDR);
        req.try_lock  = rd & hit;
        req.wr_lock   = wr & hit;
        req.wr_is_one = value_is_release(64'(wdata));
    end

endmodule

// File: rtl/hw_sem_prio_arb.sv
module hw_sem_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]     = req[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req[i];
    end

    // R4: never more than one winner
    always_comb begin
        assert ($onehot0(grant)) else $error("p_grant_onehot_r4");
    end

endmodule

// File: rtl/hw_sem_lock_core.sv
module hw_sem_lock_core
    import hw_sem_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  sem_req_t [N-1:0]     req,
    output logic [N-1:0]         grant,
    output logic                 locked,
    output logic [IDX_W-1:0]     owner,
    output logic                 err
);
    sem_flags_t       flags_q;
    logic [IDX_W-1:0] owner_q;
    logic [N-1:0]     try_vec;
    logic [N-1:0]     arb_req;
    logic             grant_any;
    logic [IDX_W-1:0] grant_idx;
    logic             release_ok;
    logic             bad_write;

    always_comb begin
        for (int i = 0; i < N; i++) try_vec[i] = req[i].try_lock;
        arb_req = flags_q.held ? '0 : try_vec;
    end

    hw_sem_prio_arb #(.N(N)) u_arb (
        .req   (arb_req),
        .grant (grant)
    );

    always_comb begin
        grant_any  = |grant;
        grant_idx  = '0;
        release_ok = 1'b0;
        bad_write  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) grant_idx = IDX_W'(i);
            if (req[i].wr_lock) begin
                if (flags_q.held && owner_q == IDX_W'(i) && req[i].wr_is_one)
                    release_ok = 1'b1;
                else
                    bad_write = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            owner_q <= '0;
        end else begin
            if (grant_any) begin
                flags_q.held <= 1'b1;
                owner_q      <= grant_idx;
            end else if (release_ok) begin
                flags_q.held <= 1'b0;
                owner_q      <= '0;
            end
            if (bad_write) flags_q.err <= 1'b1;
        end
    end

    assign locked = flags_q.held;
    assign owner  = owner_q;
    assign err    = flags_q.err;

    // R1: a grant only happens on a free lock
    p_grant_free_r1: assert property (@(posedge clk) disable iff (rst)
        grant_any |-> !locked);
    // R1: after a grant the lock is held
    p_grant_takes_r1: assert property (@(posedge clk) disable iff (rst)
        grant_any |=> locked);
    // R2: a held lock with no release keeps its owner
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (locked && !release_ok) |=> (locked && $stable(owner)));
    // R3: an owner release frees the lock
    p_release_frees_r3: assert property (@(posedge clk) disable iff (rst)
        release_ok |=> !locked);
    // R6: error flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/hw_try_lock_sem.sv
module hw_try_lock_sem
    import hw_sem_pkg::*;
#(
    parameter int NUM_AGENTS = 4,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hFD0,
    localparam int IDX_W     = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_AGENTS*ADDR_W-1:0] bus_addr,
    input  logic [NUM_AGENTS-1:0]        bus_rd,
    input  logic [NUM_AGENTS-1:0]        bus_wr,
    input  logic [NUM_AGENTS*DATA_W-1:0] bus_wdata,
    output logic [NUM_AGENTS*DATA_W-1:0] bus_rdata,
    output logic                         stat_locked,
    output logic [IDX_W-1:0]             stat_owner,
    output logic                         stat_err
);
    sem_req_t [NUM_AGENTS-1:0] req;
    logic     [NUM_AGENTS-1:0] grant;
    logic     [NUM_AGENTS-1:0] won_q;

    for (genvar i = 0; i < NUM_AGENTS; i++) begin : g_agent
        hw_sem_decode #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .LOCK_ADDR (LOCK_ADDR)
        ) u_dec (
            .addr  (bus_addr[i*ADDR_W +: ADDR_W]),
            .rd    (bus_rd[i]),
            .wr    (bus_wr[i]),
            .wdata (bus_wdata[i*DATA_W +: DATA_W]),
            .req   (req[i])
        );

        assign bus_rdata[i*DATA_W +: DATA_W] = DATA_W'(won_q[i]);

        // R7: a one on read data always follows a read strobe by one cycle
        p_rdata_after_read_r7: assert property (@(posedge clk) disable iff (rst)
            won_q[i] |-> $past(bus_rd[i]));
    end

    hw_sem_lock_core #(
        .N     (NUM_AGENTS),
        .IDX_W (IDX_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .grant  (grant),
        .locked (stat_locked),
        .owner  (stat_owner),
        .err    (stat_err)
    );

    always_ff @(posedge clk) begin
        if (rst) won_q <= '0;
        else     won_q <= grant;
    end

    // R4: at most one agent sees a one in any cycle
    p_single_winner_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(won_q));
    // R2: a winner implies the lock became held
    p_winner_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (|won_q) |-> stat_locked);

endmodule

// File: tb/hw_try_lock_sem_test.sv
module hw_try_lock_sem_test;
    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [AW-1:0] LOCK  = 12'hFD0;
    localparam logic [AW-1:0] OTHER = 12'hFD4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*AW-1:0] bus_addr = '0;
    logic [N-1:0]    bus_rd = '0;
    logic [N-1:0]    bus_wr = '0;
    logic [N*DW-1:0] bus_wdata = '0;
    logic [N*DW-1:0] bus_rdata;
    logic            stat_locked;
    logic [1:0]      stat_owner;
    logic            stat_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    hw_try_lock_sem #(.NUM_AGENTS(N), .ADDR_W(AW), .DATA_W(DW), .LOCK_ADDR(LOCK)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_locked(stat_locked),
        .stat_owner(stat_owner), .stat_err(stat_err)
    );

    typedef struct packed {
        logic [3:0] rd;
        logic [3:0] wr;
        logic [1:0] wval;
        logic       at_lock;
        logic [3:0] exp_one;
        logic       exp_held;
        logic [1:0] exp_owner;
        logic       exp_err;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{4'b0001, 4'b0000, 2'd0, 1'b1, 4'b0001, 1'b1, 2'd0, 1'b0}, // R1
        '{4'b0010, 4'b0000, 2'd0, 1'b1, 4'b0000, 1'b1, 2'd0, 1'b0}, // R2
        '{4'b0001, 4'b0000, 2'd0, 1'b1, 4'b0000, 1'b1, 2'd0, 1'b0}, // R5
        '{4'b0000, 4'b0001, 2'd1, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0}, // R3
        '{4'b1110, 4'b0000, 2'd0, 1'b1, 4'b0010, 1'b1, 2'd1, 1'b0}, // R4
        '{4'b0100, 4'b0010, 2'd1, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0}, // R7 same cycle
        '{4'b0100, 4'b0000, 2'd0, 1'b1, 4'b0100, 1'b1, 2'd2, 1'b0}, // R7 next cycle
        '{4'b1111, 4'b0000, 2'd0, 1'b0, 4'b0000, 1'b1, 2'd2, 1'b0}, // R9 read
        '{4'b0000, 4'b0100, 2'd1, 1'b0, 4'b0000, 1'b1, 2'd2, 1'b0}, // R9 write
        '{4'b0000, 4'b0100, 2'd1, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b0}, // R3
        '{4'b1100, 4'b0000, 2'd0, 1'b1, 4'b0100, 1'b1, 2'd2, 1'b0}, // R4
        '{4'b0000, 4'b1000, 2'd1, 1'b1, 4'b0000, 1'b1, 2'd2, 1'b1}, // R6 non-owner
        '{4'b0000, 4'b0100, 2'd2, 1'b1, 4'b0000, 1'b1, 2'd2, 1'b1}, // R6 bad value
        '{4'b0000, 4'b0100, 2'd1, 1'b1, 4'b0000, 1'b0, 2'd0, 1'b1}  // R3, R6 sticky
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] rd, input logic [3:0] wr,
                         input logic [DW-1:0] val, input bit at_lock);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            bus_addr[i*AW +: AW]  = at_lock ? LOCK : OTHER;
            bus_wdata[i*DW +: DW] = val;
        end
        bus_rd = rd;
        bus_wr = wr;
        @(posedge clk);
        #1;
        bus_rd = '0;
        bus_wr = '0;
    endtask

    task automatic chk_state(input string req, input logic [3:0] one, input bit held,
                             input logic [1:0] own, input bit err);
        for (int i = 0; i < N; i++)
            chk(bus_rdata[i*DW +: DW] == DW'(one[i]), req,
                bus_rdata[i*DW +: DW], longint'(one[i]));
        chk(stat_locked == held, req, stat_locked, held);
        chk(stat_owner == own, req, stat_owner, own);
        chk(stat_err == err, req, stat_err, err);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        chk_state("R8 initial", 4'b0, 1'b0, 2'd0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            apply(TBL[v].rd, TBL[v].wr, DW'(TBL[v].wval), TBL[v].at_lock);
            chk_state($sformatf("vector %0d", v), TBL[v].exp_one, TBL[v].exp_held,
                      TBL[v].exp_owner, TBL[v].exp_err);
        end

        // R8: reset clears the sticky error and the lock
        apply(4'b0010, 4'b0000, '0, 1'b1);
        chk_state("R1 take before reset", 4'b0010, 1'b1, 2'd1, 1'b1);
        do_reset();
        chk_state("R8 after reset", 4'b0000, 1'b0, 2'd0, 1'b0);

        // R2/R7: agent 3 polls while agent 0 holds, then wins after release
        apply(4'b0001, 4'b0000, '0, 1'b1);
        chk_state("R1 agent0 takes", 4'b0001, 1'b1, 2'd0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            apply(4'b1000, 4'b0000, '0, 1'b1);
            chk_state("R2 poll denied", 4'b0000, 1'b1, 2'd0, 1'b0);
        end
        apply(4'b0000, 4'b0001, 32'd1, 1'b1);
        chk_state("R3 release", 4'b0000, 1'b0, 2'd0, 1'b0);
        apply(4'b1000, 4'b0000, '0, 1'b1);
        chk_state("R7 poll wins", 4'b1000, 1'b1, 2'd3, 1'b0);
        // R7: read data is a single-cycle pulse
        @(posedge clk);
        #1;
        chk(bus_rdata == '0, "R7 rdata returns to zero", bus_rdata[DW*4-1:0], 0);
        // R6: a write of one to a free lock is an illegal release
        apply(4'b0000, 4'b1000, 32'd1, 1'b1);
        chk_state("R3 release agent3", 4'b0000, 1'b0, 2'd0, 1'b0);
        apply(4'b0000, 4'b0010, 32'd1, 1'b1);
        chk_state("R6 write to free lock", 4'b0000, 1'b0, 2'd0, 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule